// File: doc/BRIEF.md
# Grouped Interrupt Priority Resolver

This block chooses which of eight interrupt levels is serviced next. Each level collects several request sources. A per-level enable mask and a global enable qualify the levels. The surviving levels are ordered by a tree that a single 8-bit priority configuration word sets up. The tree has three groups: group A holds levels 0 and 1, group B holds levels 2, 3 and 4, and group C holds levels 5, 6 and 7. Configuration bits set the order of the groups. Other bits set the order inside each group, and inside the two-member subgroups of groups B and C.

Inside the winning level, the source with the lowest vector address is chosen. That order is fixed in hardware. The result is registered: a valid flag, the winning level number and the winning source vector appear one clock after the inputs that caused them. The configuration word is not stored inside the block. It has no reset value, so the outputs are only meaningful once software has driven it.

Top module: `irq_prio_resolver`

## Requirements
- R1: A level whose `lvl_mask` bit is 0 never wins. A level whose bit is 1 takes part in arbitration when any of its sources requests.
- R2: While `glb_en` is 0, `win_valid` goes to 0 one clock later, whatever the requests are.
- R3: When no enabled level has an active source, `win_valid`, `win_level` and `win_vec` are all 0 one clock later.
- R4: Outputs are registered. A change on the inputs is reflected exactly one rising clock edge later.
- R5: The group order code is {`prio_cfg[7]`, `prio_cfg[4]`, `prio_cfg[1]`}. The codes map as follows: 001 gives B>C>A, 010 gives A>B>C, 011 gives B>A>C, 100 gives C>A>B, 101 gives C>B>A and 110 gives A>C>B. Codes 000 and 111 give A>B>C. The first group in this order that has an enabled active level wins.
- R6: Inside group A, `prio_cfg[0]`=0 ranks level 0 above level 1, and 1 ranks level 1 above level 0.
- R7: Inside group B, `prio_cfg[2]`=0 ranks level 2 above the pair {3,4}, and 1 ranks the pair first. `prio_cfg[3]`=0 ranks level 3 above level 4, and 1 ranks level 4 first.
- R8: Inside group C, `prio_cfg[5]`=0 ranks level 5 above the pair {6,7}, and 1 ranks the pair first. `prio_cfg[6]`=0 ranks level 6 above level 7, and 1 ranks level 7 first.
- R9: Source s of level l is request bit `irq_req[l*4+s]` and has vector 0x40 + 2*(4*l + s) with default parameters. Among the active sources of the winning level, the lowest s (lowest vector) wins.
- R10: While reset is asserted, and directly after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 32 | Request lines, four sources per level, level l in bits [4l+3:4l] |
| lvl_mask | input | 8 | Per-level enable, 1 enables |
| prio_cfg | input | 8 | Priority configuration word |
| glb_en | input | 1 | Global interrupt enable |
| win_valid | output | 1 | A winner is presented |
| win_level | output | 3 | Winning level number |
| win_vec | output | 8 | Vector address of the winning source |

## Verification
The level arbitration and the source choice inside a level both resolve in the same cycle. The vector output is only right if both are right together. The bench provokes this by raising several sources on many levels at once and then sweeping the group code and the in-group bits. It also masks away the levels that would otherwise win, so the winner moves to a level that has its own mix of active sources. A scoreboard model, built from the ordering rules alone, predicts the level and vector for each cycle and compares them one clock later.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int NUM_LVL = 8;
    localparam int LVL_W   = 3;
    localparam int NUM_GRP = 3;

    typedef enum logic [1:0] {
        GRP_A = 2'd0,
        GRP_B = 2'd1,
        GRP_C = 2'd2
    } grp_e;

    typedef struct packed {
        grp_e first;
        grp_e second;
        grp_e third;
    } grp_order_t;

    // Group order code is {cfg[7], cfg[4], cfg[1]}
    function automatic grp_order_t decode_order(input logic [2:0] code);
        grp_order_t o;
        case (code)
            3'b001:  o = '{GRP_B, GRP_C, GRP_A};
            3'b011:  o = '{GRP_B, GRP_A, GRP_C};
            3'b100:  o = '{GRP_C, GRP_A, GRP_B};
            3'b101:  o = '{GRP_C, GRP_B, GRP_A};
            3'b110:  o = '{GRP_A, GRP_C, GRP_B};
            default: o = '{GRP_A, GRP_B, GRP_C};
        endcase
        return o;
    endfunction

    function automatic logic [LVL_W-1:0] grp_base(input grp_e g);
        case (g)
            GRP_B:   return 3'd2;
            GRP_C:   return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/irq_src_pick.sv
module irq_src_pick #(
    parameter int N_SRC = 4,
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] req,
    output logic             any,
    output logic [SRC_W-1:0] idx
);
    // Lowest index equals lowest vector address: it is scanned last so it wins
    always_comb begin
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) idx = SRC_W'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/irq_group_arb.sv
module irq_group_arb (
    input  logic [2:0] act,      // member 0 is the lead, members 1 and 2 form the pair
    input  logic       pair_first,
    input  logic       pair_swap,
    output logic       any,
    output logic [1:0] idx
);
    logic       pair_any;
    logic [1:0] pair_idx;

    always_comb begin
        pair_any = act[1] | act[2];
        if (!pair_swap) pair_idx = act[1] ? 2'd1 : 2'd2;
        else            pair_idx = act[2] ? 2'd2 : 2'd1;

        if (!pair_first) idx = act[0] ? 2'd0 : pair_idx;
        else             idx = pair_any ? pair_idx : 2'd0;

        any = act[0] | pair_any;
    end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter int SRC_PER_LVL = 4,
    parameter int VEC_W       = 8,
    parameter int VEC_BASE    = 'h40,
    parameter int VEC_STEP    = 2,
    localparam int REQ_W      = NUM_LVL * SRC_PER_LVL,
    localparam int SRC_W      = (SRC_PER_LVL > 1) ? $clog2(SRC_PER_LVL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REQ_W-1:0] irq_req,
    input  logic [7:0]       lvl_mask,
    input  logic [7:0]       prio_cfg,
    input  logic             glb_en,
    output logic             win_valid,
    output logic [LVL_W-1:0] win_level,
    output logic [VEC_W-1:0] win_vec
);

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] level;
        logic [VEC_W-1:0] vec;
    } win_t;

    win_t st_d, st_q;

    logic [NUM_LVL-1:0] src_any;
    logic [SRC_W-1:0]   src_idx [NUM_LVL];
    logic [NUM_LVL-1:0] lvl_act;

    logic       grp_any [NUM_GRP];
    logic [1:0] grp_idx [NUM_GRP];

    // Per-level source selection and qualification
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        irq_src_pick #(.N_SRC(SRC_PER_LVL)) u_pick (
            .req (irq_req[l*SRC_PER_LVL +: SRC_PER_LVL]),
            .any (src_any[l]),
            .idx (src_idx[l])
        );
        assign lvl_act[l] = src_any[l] & lvl_mask[l] & glb_en;
    end

    // Group A uses the lead/pair arbiter with the second pair member tied off
    irq_group_arb u_grp_a (
        .act        ({1'b0, lvl_act[1], lvl_act[0]}),
        .pair_first (prio_cfg[0]),
        .pair_swap  (1'b0),
        .any        (grp_any[GRP_A]),
        .idx        (grp_idx[GRP_A])
    );

    irq_group_arb u_grp_b (
        .act        (lvl_act[4:2]),
        .pair_first (prio_cfg[2]),
        .pair_swap  (prio_cfg[3]),
        .any        (grp_any[GRP_B]),
        .idx        (grp_idx[GRP_B])
    );

    irq_group_arb u_grp_c (
        .act        (lvl_act[7:5]),
        .pair_first (prio_cfg[5]),
        .pair_swap  (prio_cfg[6]),
        .any        (grp_any[GRP_C]),
        .idx        (grp_idx[GRP_C])
    );

    always_comb begin
        grp_order_t       ord;
        grp_e             slot [NUM_GRP];
        logic             found;
        logic [LVL_W-1:0] lvl;

        ord     = decode_order({prio_cfg[7], prio_cfg[4], prio_cfg[1]});
        slot[0] = ord.first;
        slot[1] = ord.second;
        slot[2] = ord.third;
        found   = 1'b0;
        lvl     = '0;

        for (int g = 0; g < NUM_GRP; g++) begin
            if (!found && grp_any[slot[g]]) begin
                found = 1'b1;
                lvl   = grp_base(slot[g]) + {1'b0, grp_idx[slot[g]]};
            end
        end

        st_d = '0;
        if (found) begin
            st_d.valid = 1'b1;
            st_d.level = lvl;
            st_d.vec   = VEC_W'(VEC_BASE + VEC_STEP *
                         (int'(lvl) * SRC_PER_LVL + int'(src_idx[lvl])));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_valid = st_q.valid;
    assign win_level = st_q.level;
    assign win_vec   = st_q.vec;

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
    import irq_prio_pkg::*;
#(
    parameter int SRC_PER_LVL = 4,
    parameter int VEC_W       = 8,
    parameter int VEC_BASE    = 'h40,
    parameter int VEC_STEP    = 2,
    localparam int REQ_W      = NUM_LVL * SRC_PER_LVL,
    localparam int IDX_W      = (REQ_W > 1) ? $clog2(REQ_W) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REQ_W-1:0] irq_req,
    input logic [7:0]       lvl_mask,
    input logic [7:0]       prio_cfg,
    input logic             glb_en,
    input logic             win_valid,
    input logic [LVL_W-1:0] win_level,
    input logic [VEC_W-1:0] win_vec
);
    logic             armed;
    logic [REQ_W-1:0] req_q;
    logic [7:0]       mask_q, cfg_q;
    logic             en_q;
    logic [7:0]       act_q;
    logic [IDX_W-1:0] flat_idx;
    logic [2:0]       code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            req_q  <= '0;
            mask_q <= '0;
            cfg_q  <= '0;
            en_q   <= 1'b0;
        end else begin
            armed  <= 1'b1;
            req_q  <= irq_req;
            mask_q <= lvl_mask;
            cfg_q  <= prio_cfg;
            en_q   <= glb_en;
        end
    end

    always_comb begin
        for (int l = 0; l < NUM_LVL; l++)
            act_q[l] = (|req_q[l*SRC_PER_LVL +: SRC_PER_LVL]) & mask_q[l] & en_q;
        flat_idx = IDX_W'((int'(win_vec) - VEC_BASE) / VEC_STEP);
        code_q   = {cfg_q[7], cfg_q[4], cfg_q[1]};
    end

    p_mask_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        armed && win_valid |-> mask_q[win_level]);

    p_enable_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !en_q |-> !win_valid);

    p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |-> (win_level == '0) && (win_vec == '0));

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (win_valid == (|act_q)));

    p_group_a_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && code_q == 3'b010 && (|act_q[1:0]) |-> win_level < 3'd2);

    p_group_a_inner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed && act_q == 8'b0000_0011 |-> win_level == (cfg_q[0] ? 3'd1 : 3'd0));

    p_group_b_inner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        armed && act_q == 8'b0001_1100 |->
        win_level == (cfg_q[2] ? (cfg_q[3] ? 3'd4 : 3'd3) : 3'd2));

    p_group_c_inner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed && act_q == 8'b1110_0000 |->
        win_level == (cfg_q[5] ? (cfg_q[6] ? 3'd7 : 3'd6) : 3'd5));

    p_source_requested_r9: assert property (@(posedge clk) disable iff (!rst_n)
        armed && win_valid |-> req_q[flat_idx]);

endmodule

bind irq_prio_resolver irq_prio_chk #(
    .SRC_PER_LVL (SRC_PER_LVL),
    .VEC_W       (VEC_W),
    .VEC_BASE    (VEC_BASE),
    .VEC_STEP    (VEC_STEP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .lvl_mask  (lvl_mask),
    .prio_cfg  (prio_cfg),
    .glb_en    (glb_en),
    .win_valid (win_valid),
    .win_level (win_level),
    .win_vec   (win_vec)
);

// File: tb/tb_irq_prio_resolver.sv
`timescale 1ns/1ps
module tb_irq_prio_resolver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_req = '0;
    logic [7:0]  lvl_mask = '0;
    logic [7:0]  prio_cfg = '0;
    logic        glb_en = 1'b0;
    logic        win_valid;
    logic [2:0]  win_level;
    logic [7:0]  win_vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic       v;
        logic [2:0] lv;
        logic [7:0] vc;
        string      tag;
    } exp_t;

    exp_t sb_q [$];

    always #4 clk = ~clk;

    irq_prio_resolver dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .lvl_mask  (lvl_mask),
        .prio_cfg  (prio_cfg),
        .glb_en    (glb_en),
        .win_valid (win_valid),
        .win_level (win_level),
        .win_vec   (win_vec)
    );

    // cfg layout: [7]=code2 [6]=C pair swap [5]=C pair first [4]=code1
    //             [3]=B pair swap [2]=B pair first [1]=code0 [0]=A swap
    function automatic logic [7:0] mkcfg(input logic [2:0] code, input logic a0,
                                         input logic b2, input logic b3,
                                         input logic c5, input logic c6);
        return {code[2], c6, c5, code[1], b3, b2, code[0], a0};
    endfunction

    function automatic void model(input logic [31:0] rq, input logic [7:0] mk,
                                  input logic [7:0] cf, input logic en,
                                  output logic v, output logic [2:0] lv,
                                  output logic [7:0] vc);
        int grp[3];
        int ord[8];
        int n;
        int mem[3];
        int cnt;
        int p0, p1;
        n = 0;
        case ({cf[7], cf[4], cf[1]})
            3'b001:  grp = '{1, 2, 0};
            3'b011:  grp = '{1, 0, 2};
            3'b100:  grp = '{2, 0, 1};
            3'b101:  grp = '{2, 1, 0};
            3'b110:  grp = '{0, 2, 1};
            default: grp = '{0, 1, 2};
        endcase
        for (int g = 0; g < 3; g++) begin
            if (grp[g] == 0) begin
                cnt = 2;
                mem = cf[0] ? '{1, 0, 0} : '{0, 1, 0};
            end else if (grp[g] == 1) begin
                cnt = 3;
                p0 = cf[3] ? 4 : 3;
                p1 = cf[3] ? 3 : 4;
                mem = cf[2] ? '{p0, p1, 2} : '{2, p0, p1};
            end else begin
                cnt = 3;
                p0 = cf[6] ? 7 : 6;
                p1 = cf[6] ? 6 : 7;
                mem = cf[5] ? '{p0, p1, 5} : '{5, p0, p1};
            end
            for (int k = 0; k < cnt; k++) begin
                ord[n] = mem[k];
                n = n + 1;
            end
        end
        v = 1'b0; lv = '0; vc = '0;
        for (int i = 0; i < 8; i++) begin
            if (!v && en && mk[ord[i]] && (rq[ord[i]*4 +: 4] != 4'b0)) begin
                v  = 1'b1;
                lv = 3'(ord[i]);
                for (int s = 3; s >= 0; s--)
                    if (rq[ord[i]*4 + s]) vc = 8'(8'h40 + 2 * (ord[i] * 4 + s));
            end
        end
    endfunction

    task automatic apply(input logic [31:0] rq, input logic [7:0] mk,
                         input logic [7:0] cf, input logic en, input string tag);
        exp_t e;
        @(negedge clk);
        irq_req  = rq;
        lvl_mask = mk;
        prio_cfg = cf;
        glb_en   = en;
        model(rq, mk, cf, en, e.v, e.lv, e.vc);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: each item was pushed at the falling edge before this rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (win_valid !== e.v || win_level !== e.lv || win_vec !== e.vc) begin
                    errors++;
                    $display("FAIL %s: got v=%0b lvl=%0d vec=%h, expected v=%0b lvl=%0d vec=%h",
                             e.tag, win_valid, win_level, win_vec, e.v, e.lv, e.vc);
                end
            end
        end
    end

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(64'd200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R10: reset state
        checks++;
        if (win_valid !== 1'b0 || win_level !== 3'd0 || win_vec !== 8'h00) begin
            errors++;
            $display("FAIL R10: got v=%0b lvl=%0d vec=%h, expected 0 0 00",
                     win_valid, win_level, win_vec);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (win_valid !== 1'b0 || win_vec !== 8'h00) begin
            errors++;
            $display("FAIL R10: after release got v=%0b vec=%h, expected 0 00", win_valid, win_vec);
        end

        // R9: each level alone, one source each
        for (int l = 0; l < 8; l++)
            apply(32'h1 << (l * 4 + (l % 4)), 8'hFF, mkcfg(3'b010, 0, 0, 0, 0, 0), 1'b1, "R9 single");

        // R9: multiple sources in a level, lowest wins
        apply(32'h0000_A000, 8'hFF, 8'h00, 1'b1, "R9 multi 1010");
        apply(32'h0000_8000, 8'hFF, 8'h00, 1'b1, "R9 top source");
        apply(32'hF000_0000, 8'hFF, 8'h00, 1'b1, "R9 all sources");

        // R1: masking
        apply(32'hFFFF_FFFF, 8'h00, 8'h00, 1'b1, "R1 all masked");
        for (int l = 0; l < 8; l++)
            apply(32'h6666_6666, 8'h1 << l, 8'h00, 1'b1, "R1 one enabled");
        apply(32'h0000_0F0F, 8'hFE, 8'h00, 1'b1, "R1 mask level0");

        // R2: global enable
        apply(32'hFFFF_FFFF, 8'hFF, 8'h00, 1'b0, "R2 global off");

        // R3: nothing requested
        apply(32'h0, 8'hFF, 8'h00, 1'b1, "R3 idle");

        // R4: one-cycle pulse then idle
        apply(32'h0000_0100, 8'hFF, 8'h00, 1'b1, "R4 pulse");
        apply(32'h0, 8'hFF, 8'h00, 1'b1, "R4 after pulse");

        // R5: every group code with all levels active
        for (int c = 0; c < 8; c++)
            apply(32'h2482_4824, 8'hFF, mkcfg(3'(c), 0, 0, 0, 0, 0), 1'b1, "R5 group order");
        for (int c = 0; c < 8; c++)
            apply(32'h2482_4824, 8'hDE, mkcfg(3'(c), 1, 1, 1, 1, 1), 1'b1, "R5 masked order");

        // R6: group A inner
        apply(32'h0000_0031, 8'hFF, mkcfg(3'b010, 0, 0, 0, 0, 0), 1'b1, "R6 a0=0");
        apply(32'h0000_0031, 8'hFF, mkcfg(3'b010, 1, 0, 0, 0, 0), 1'b1, "R6 a0=1");

        // R7: group B inner
        for (int b = 0; b < 4; b++) begin
            apply(32'h0001_1100, 8'hFF, mkcfg(3'b001, 0, b[0], b[1], 0, 0), 1'b1, "R7 all B");
            apply(32'h0001_1000, 8'hFF, mkcfg(3'b001, 0, b[0], b[1], 0, 0), 1'b1, "R7 pair only");
            apply(32'h0000_0100, 8'hFF, mkcfg(3'b001, 0, b[0], b[1], 0, 0), 1'b1, "R7 lead only");
        end

        // R8: group C inner
        for (int b = 0; b < 4; b++) begin
            apply(32'h1110_0000, 8'hFF, mkcfg(3'b101, 0, 0, 0, b[0], b[1]), 1'b1, "R8 all C");
            apply(32'h1100_0000, 8'hFF, mkcfg(3'b101, 0, 0, 0, b[0], b[1]), 1'b1, "R8 pair only");
            apply(32'h0010_0000, 8'hFF, mkcfg(3'b101, 0, 0, 0, b[0], b[1]), 1'b1, "R8 lead only");
        end

        // Mixed traffic: group order, in-group bits, mask and source pick together
        for (int i = 0; i < 300; i++) begin
            r = $urandom;
            apply(r & $urandom, 8'($urandom), 8'($urandom), ($urandom % 8) != 0, "R5 mix");
        end

        repeat (3) @(negedge clk);
        done = 1;
        summary();
    end

endmodule